// File: doc/BRIEF.md
# External Interrupt Enable and Priority Controller

This block collects 32 level-sensitive external interrupt request lines, samples them once into a pending register, and masks them with a per-line enable register. From the masked set it produces the standard machine external-interrupt pending flag and the index of the lowest-numbered line that is both pending and enabled. It also combines that flag with the global machine interrupt enable and the machine external-interrupt enable to tell the core whether an external interrupt should be taken now.

Software reaches the block through a simple CSR port. A write strobe with an address and data updates the enable register on the next rising edge. The read data is a combinational function of the address and the current register state. The enable register can be read and written. The pending register and the lowest-index register can only be read. A pending bit follows its request line and is cleared only when the requester deasserts it. Trap sequencing and the clearing of requests at their source belong to other parts of the core.

Top module: `irq_ext_ctrl`

## Requirements
- R1: After reset the enable register (CSR 0xbe0) reads 0xffffffff, the pending register (CSR 0xfe0) reads 0, and `meip_o`, `take_irq_o` and `lowest_idx_o` are all 0.
- R2: A write with `csr_we_i` high to address 0xbe0 loads `csr_wdata_i` into the enable register at the next rising edge. Bit n (1 = enabled) gates request line n, and reads of 0xbe0 return the stored value.
- R3: Bit n of the pending register (CSR 0xfe0) equals `irq_i[n]` as sampled at the most recent rising edge. Writes to 0xfe0 change neither the pending register nor any output.
- R4: `meip_o` is 1 exactly when some bit is set in both the pending register and the enable register.
- R5: `take_irq_o` is 1 exactly when `meip_o`, `mstatus_mie_i` and `mie_meie_i` are all 1.
- R6: `lowest_idx_o`, and bits 4:0 of a read of CSR 0xfe4, hold the lowest n for which pending[n] AND enable[n] is 1. Bits 31:5 of that read are 0.
- R7: When no line is both pending and enabled, `lowest_idx_o` and a read of 0xfe4 are 0.
- R8: Reads of the reserved addresses 0xbe1–0xbe3 and 0xfe1–0xfe3, and of any other unmapped address, return 0. Writes to them, and to 0xfe4, leave the enable register unchanged.
- R9: A change on `irq_i` reaches `meip_o`, `lowest_idx_o`, `take_irq_o` and the pending register together, one rising edge later, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Level-sensitive external request lines |
| mstatus_mie_i | input | 1 | Global machine interrupt enable |
| mie_meie_i | input | 1 | Machine external-interrupt enable |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_we_i | input | 1 | CSR write strobe |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data for `csr_addr_i` |
| meip_o | output | 1 | Machine external interrupt pending flag |
| lowest_idx_o | output | 5 | Lowest pending-and-enabled line index |
| take_irq_o | output | 1 | External interrupt should be taken |

## Verification
The assertions assume that every input is at a known level once reset is released and that the request lines change only between clock edges, so the sampled pending value can be compared against the previous cycle's `irq_i`. The pending-latency check is enabled only after one full edge out of reset, because the first sample is taken while reset still holds the register. The stimulus drives every input to a defined value before reset is released. It changes the inputs only a short time after each rising edge. It then samples the outputs before the next edge, once the combinational read path has settled.

// File: rtl/irq_ext_pkg.sv
package irq_ext_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned NUM_IRQ = 32;
  localparam int unsigned IDX_W   = $clog2(NUM_IRQ);
  localparam int unsigned ADDR_W  = 12;

  localparam logic [ADDR_W-1:0] CSR_EN_ADDR   = 12'hbe0;
  localparam logic [ADDR_W-1:0] CSR_PEND_ADDR = 12'hfe0;
  localparam logic [ADDR_W-1:0] CSR_LOW_ADDR  = 12'hfe4;

  typedef logic [NUM_IRQ-1:0] irq_vec_t;
  typedef logic [IDX_W-1:0]   irq_idx_t;
endpackage

// File: rtl/irq_line_sampler.sv
module irq_line_sampler #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] irq_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q;

  for (genvar g = 0; g < W; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[g] <= 1'b0;
      else         pend_q[g] <= irq_i[g];
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_lsb_encoder.sv
module irq_lsb_encoder #(
  parameter int unsigned W     = 32,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    idx_o = '0;
    for (int i = 0; i < int'(W); i++) begin
      if (!found && vec_i[i]) begin
        idx_o = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  assign any_o = |vec_i;
endmodule

// File: rtl/irq_csr_file.sv
module irq_csr_file
  import irq_ext_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic              csr_we_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  input  irq_vec_t          pend_i,
  input  irq_idx_t          lowest_i,
  output irq_vec_t          en_o,
  output logic [XLEN-1:0]   rdata_o
);
  irq_vec_t en_q;
  logic     en_wr;

  assign en_wr = csr_we_i && (csr_addr_i == CSR_EN_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '1;
    else if (en_wr) en_q <= csr_wdata_i[NUM_IRQ-1:0];
  end

  always_comb begin
    unique case (csr_addr_i)
      CSR_EN_ADDR:   rdata_o = XLEN'(en_q);
      CSR_PEND_ADDR: rdata_o = XLEN'(pend_i);
      CSR_LOW_ADDR:  rdata_o = {{(XLEN-IDX_W){1'b0}}, lowest_i};
      default:       rdata_o = '0;
    endcase
  end

  assign en_o = en_q;

  assert_en_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_addr_i != CSR_EN_ADDR) |=> (en_q == $past(en_q)));
  assert_en_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr |=> (en_q == $past(csr_wdata_i[NUM_IRQ-1:0])));
endmodule

// File: rtl/irq_ext_ctrl.sv
module irq_ext_ctrl
  import irq_ext_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic              mstatus_mie_i,
  input  logic              mie_meie_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic              csr_we_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              meip_o,
  output logic [IDX_W-1:0]  lowest_idx_o,
  output logic              take_irq_o
);
  irq_vec_t pend;
  irq_vec_t en;
  irq_vec_t active;
  irq_idx_t lowest;
  logic     any_active;

  irq_line_sampler #(.W(NUM_IRQ)) u_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .pend_o (pend)
  );

  assign active = pend & en;

  irq_lsb_encoder #(.W(NUM_IRQ), .IDX_W(IDX_W)) u_encoder (
    .vec_i (active),
    .idx_o (lowest),
    .any_o (any_active)
  );

  irq_csr_file u_csr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .csr_addr_i  (csr_addr_i),
    .csr_we_i    (csr_we_i),
    .csr_wdata_i (csr_wdata_i),
    .pend_i      (pend),
    .lowest_i    (lowest),
    .en_o        (en),
    .rdata_o     (csr_rdata_o)
  );

  assign meip_o       = any_active;
  assign lowest_idx_o = lowest;
  assign take_irq_o   = any_active & mstatus_mie_i & mie_meie_i;

  // one full edge out of reset before pend may be compared with irq_i
  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  assert_pend_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> (pend == $past(irq_i)));
  assert_take_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_o |-> (meip_o && mstatus_mie_i && mie_meie_i));
  assert_lowest_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meip_o |-> (pend[lowest_idx_o] && en[lowest_idx_o]));
  assert_lowest_min_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meip_o |-> ((pend & en & ((irq_vec_t'(1) << lowest_idx_o) - 1'b1)) == '0));
  assert_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !meip_o |-> (lowest_idx_o == '0 && !take_irq_o));
endmodule

// File: tb/tb_irq_ext_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ext_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_i = '0;
  logic        mstatus_mie_i = 1'b0;
  logic        mie_meie_i = 1'b0;
  logic [11:0] csr_addr_i = 12'hbe0;
  logic        csr_we_i = 1'b0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_rdata_o;
  logic        meip_o;
  logic [4:0]  lowest_idx_o;
  logic        take_irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] exp_en;
  logic [31:0] exp_pend;
  logic [31:0] rng = 32'h1234_5678;

  always #2.5 clk_i = ~clk_i;

  irq_ext_ctrl dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] low_of(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) low_of = 5'(i);
    if (v == 0) low_of = 5'd0;
  endfunction

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    csr_we_i = 1'b0; csr_addr_i = a; #0.5; d = csr_rdata_o;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    csr_addr_i = a; csr_wdata_i = d; csr_we_i = 1'b1;
    tick();
    csr_we_i = 1'b0;
  endtask

  task automatic check_outputs(input string tag);
    logic [31:0] act;
    logic [31:0] m;
    m = exp_pend & exp_en;
    chk({tag, " R4 meip"}, 32'(meip_o), 32'(m != 0));
    chk({tag, " R6 lowest port"}, 32'(lowest_idx_o), 32'(low_of(m)));
    chk({tag, " R5 take"}, 32'(take_irq_o), 32'((m != 0) & mstatus_mie_i & mie_meie_i));
    rd(12'hfe4, act);
    chk({tag, " R6 lowest csr"}, act, {27'd0, low_of(m)});
    rd(12'hfe0, act);
    chk({tag, " R3 pend csr"}, act, exp_pend);
  endtask

  initial begin
    logic [31:0] d;
    #20;
    rd(12'hbe0, d); chk("R1 en reset", d, 32'hffff_ffff);
    rd(12'hfe0, d); chk("R1 pend reset", d, 32'h0);
    chk("R1 meip reset", 32'(meip_o), 0);
    chk("R1 take reset", 32'(take_irq_o), 0);
    chk("R1 idx reset", 32'(lowest_idx_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    tick();
    exp_en = 32'hffff_ffff; exp_pend = '0;

    // single lines and upward masks, all enabled
    for (int i = 0; i < 32; i++) begin
      irq_i = 32'h1 << i; tick(); exp_pend = irq_i;
      check_outputs("single");
      irq_i = 32'hffff_ffff << i; tick(); exp_pend = irq_i;
      check_outputs("upmask");
    end

    // R7: nothing pending
    irq_i = '0; tick(); exp_pend = '0;
    check_outputs("R7 idle");

    // R2 enable write / read-back
    wr(12'hbe0, 32'h0f0f_00f0); exp_en = 32'h0f0f_00f0;
    rd(12'hbe0, d); chk("R2 en readback", d, exp_en);

    // R7: pending but all masked
    irq_i = ~exp_en; tick(); exp_pend = irq_i;
    check_outputs("R7 masked");

    // random sweep with enables and global gates
    for (int k = 0; k < 300; k++) begin
      rng = next_rng(rng);
      if (k % 7 == 0) begin
        wr(12'hbe0, rng ^ 32'h5a5a_a5a5);
        exp_en = rng ^ 32'h5a5a_a5a5;
        rd(12'hbe0, d); chk("R2 en rand", d, exp_en);
        rng = next_rng(rng);
      end
      irq_i = rng & next_rng(rng);
      mstatus_mie_i = rng[3]; mie_meie_i = rng[9];
      tick(); exp_pend = irq_i;
      check_outputs("rand");
    end

    // R5 exhaustive gates with an active line
    wr(12'hbe0, 32'hffff_ffff); exp_en = '1;
    irq_i = 32'h0000_0100; tick(); exp_pend = irq_i;
    for (int g = 0; g < 4; g++) begin
      mstatus_mie_i = g[0]; mie_meie_i = g[1]; #0.5;
      chk("R5 gate", 32'(take_irq_o), 32'(g == 3));
    end

    // R9 latency: new irq not visible before the edge
    irq_i = 32'h0000_0001; #0.5;
    chk("R9 before edge idx", 32'(lowest_idx_o), 32'd8);
    tick(); exp_pend = irq_i;
    chk("R9 after edge idx", 32'(lowest_idx_o), 32'd0);
    irq_i = '0; #0.5;
    chk("R9 before edge meip", 32'(meip_o), 1);
    tick(); exp_pend = '0;
    chk("R9 after edge meip", 32'(meip_o), 0);

    // R3 write to pending ignored
    irq_i = 32'h00a0_0000; tick(); exp_pend = irq_i;
    wr(12'hfe0, 32'h0); check_outputs("R3 pend write");
    // R8 writes to read-only / reserved addresses do not touch enable
    wr(12'hbe0, 32'h00ff_00ff); exp_en = 32'h00ff_00ff;
    for (int a = 0; a < 8; a++) begin
      logic [11:0] ad;
      ad = (a < 3) ? 12'(12'hbe1 + a) : (a < 6) ? 12'(12'hfe1 + a - 3) : (a == 6) ? 12'hfe4 : 12'h300;
      wr(ad, 32'hffff_0000);
      rd(12'hbe0, d); chk("R8 en unchanged", d, exp_en);
      if (ad != 12'hfe4) begin
        rd(ad, d); chk("R8 reserved reads 0", d, 32'h0);
      end
    end
    check_outputs("R8 after");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule